// File: doc/BRIEF.md
# Board-Addressed SPI Register Slave

This block lets several cards hang off one shared SPI bus and still be reached one at a time. Each card has a 4-bit identity on a static input, set by switches or strap resistors. A master frames each access with an active-low select. Within the frame it sends a 16-bit address, then a single read/write bit, then one data byte. The top nibble of the address names the target card. The remaining 12 bits pick a byte inside that card's local register space.

SCK, select and MOSI are brought into the faster system clock through two-flop synchronisers, and their edges are detected there. A transaction state machine collects the address. It checks the card identity as soon as four bits have arrived. On a match it issues a single-cycle read or write strobe on a simple register-file port. On a mismatch it keeps its MISO output-enable low and lets the rest of the frame pass until select is released.

The SCK half-period must span several system clocks so that the synchronisers and the one-cycle read fetch fit between edges.

Top module: `spi_id_regslave`

## Requirements
- R1: After synchronous reset, `spi_miso_oe` and `spi_miso` are low and neither `reg_wr_en` nor `reg_rd_en` pulses until a matching frame is received.
- R2: While select is low, MOSI is sampled on rising SCK edges (SPI mode 0). The order is 16 address bits MSB first, then one flag bit (1 = read, 0 = write), then 8 data bits MSB first.
- R3: Address bits [15:12] are compared with `board_id` once the fourth bit is in. On a mismatch, the rest of the frame produces no `reg_wr_en` or `reg_rd_en` pulse and `spi_miso_oe` stays low.
- R4: In a matching write frame, exactly one one-cycle `reg_wr_en` pulse follows the eighth data bit. It carries address bits [11:0] on `reg_wr_addr` and the data byte on `reg_wr_data`.
- R5: In a matching read frame, one one-cycle `reg_rd_en` pulse with the 12-bit local address follows the flag bit. `reg_rd_data` is taken on the clock after that pulse. The byte is shifted out MSB first on `spi_miso`, which changes only after falling SCK edges, with `spi_miso_oe` high during the data phase.
- R6: If select rises before the eighth data bit, the frame is dropped with no write strobe. The block returns to idle, and the next frame decodes normally.
- R7: If the select release is seen in the same system cycle as the eighth data edge, the release wins and no write strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| board_id | input | 4 | Strapped card identity |
| spi_sel_n | input | 1 | Active-low frame select from the master |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial read data to the master |
| spi_miso_oe | output | 1 | Output enable for the shared MISO driver |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 12 | Local write address |
| reg_wr_data | output | 8 | Write data byte |
| reg_rd_en | output | 1 | One-cycle register read request |
| reg_rd_addr | output | 12 | Local read address |
| reg_rd_data | input | 8 | Read byte, valid the cycle after `reg_rd_en` |

## Verification
The write commit on the eighth rising SCK edge and the abort on select release can arrive in the same system cycle. SCK and select pass through synchronisers of equal depth, so the bench provokes this by raising the last SCK edge and select at the same instant in a write frame. It judges the result by counting `reg_wr_en` pulses, which must not increase, and by reading the target byte back to confirm that it is unchanged.

// File: rtl/spi_id_pkg.sv
package spi_id_pkg;
    localparam int ID_W   = 4;
    localparam int LOC_W  = 12;
    localparam int ADDR_W = ID_W + LOC_W;
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(ADDR_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_FLAG,
        ST_DATA,
        ST_HOLD
    } frame_state_t;

    typedef struct packed {
        logic              en;
        logic [LOC_W-1:0]  addr;
        logic [DATA_W-1:0] data;
    } reg_wr_t;

    function automatic logic id_hit(input logic [ID_W-1:0] got, input logic [ID_W-1:0] mine);
        return got == mine;
    endfunction
endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic sel_n_in,
    input  logic sck_in,
    input  logic mosi_in,
    output logic sel_act,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_bit
);
    logic [1:0] sel_q, sck_q, mosi_q;
    logic       sck_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= 2'b11;
            sck_q    <= 2'b00;
            mosi_q   <= 2'b00;
            sck_prev <= 1'b0;
        end else begin
            sel_q    <= {sel_q[0], sel_n_in};
            sck_q    <= {sck_q[0], sck_in};
            mosi_q   <= {mosi_q[0], mosi_in};
            sck_prev <= sck_q[1];
        end
    end

    assign sel_act  = ~sel_q[1];
    assign sck_rise = sck_q[1] & ~sck_prev;
    assign sck_fall = ~sck_q[1] & sck_prev;
    assign mosi_bit = mosi_q[1];
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_id_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   board_id,
    input  logic              sel_act,
    input  logic              sck_rise,
    input  logic              mosi_bit,
    output reg_wr_t           wr,
    output logic              rd_en,
    output logic [LOC_W-1:0]  loc_addr,
    output logic              tx_active,
    output logic              tx_shift_ok
);
    localparam logic [CNT_W-1:0] ID_LAST   = CNT_W'(ID_W - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    frame_state_t          state;
    logic [CNT_W-1:0]      cnt;
    logic [LOC_W-1:0]      addr_sh;
    logic [DATA_W-2:0]     data_sh;
    logic                  matched;
    logic                  is_read;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            addr_sh <= '0;
            data_sh <= '0;
            matched <= 1'b0;
            is_read <= 1'b0;
            rd_en   <= 1'b0;
            wr      <= '0;
        end else begin
            rd_en  <= 1'b0;
            wr.en  <= 1'b0;
            if (!sel_act) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        state   <= ST_ADDR;
                        cnt     <= '0;
                        matched <= 1'b0;
                        is_read <= 1'b0;
                    end
                    ST_ADDR: if (sck_rise) begin
                        addr_sh <= {addr_sh[LOC_W-2:0], mosi_bit};
                        cnt     <= cnt + 1'b1;
                        if (cnt == ID_LAST) begin
                            if (id_hit({addr_sh[ID_W-2:0], mosi_bit}, board_id))
                                matched <= 1'b1;
                            else
                                state <= ST_HOLD;
                        end
                        if (cnt == ADDR_LAST) state <= ST_FLAG;
                    end
                    ST_FLAG: if (sck_rise) begin
                        is_read <= mosi_bit;
                        rd_en   <= mosi_bit;
                        cnt     <= '0;
                        state   <= ST_DATA;
                    end
                    ST_DATA: if (sck_rise) begin
                        data_sh <= {data_sh[DATA_W-3:0], mosi_bit};
                        cnt     <= cnt + 1'b1;
                        if (cnt == DATA_LAST) begin
                            state <= ST_HOLD;
                            if (!is_read) begin
                                wr.en   <= 1'b1;
                                wr.addr <= addr_sh;
                                wr.data <= {data_sh, mosi_bit};
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign loc_addr    = addr_sh;
    assign tx_active   = (state == ST_DATA) && is_read && matched;
    assign tx_shift_ok = tx_active && (cnt != '0);

    assert_abort_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !sel_act |=> (state == ST_IDLE));
    assert_wr_needs_match_R3: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> matched);
    assert_rd_needs_match_R3: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> matched);
    assert_wr_single_R4: assert property (@(posedge clk) disable iff (rst)
        wr.en |=> !wr.en);
    assert_rd_single_R5: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !rd_en);
endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter
    import spi_id_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              sck_fall,
    input  logic              shift_ok,
    output logic              tx_bit
);
    logic [DATA_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)                       sh <= '0;
        else if (load)                 sh <= load_data;
        else if (sck_fall && shift_ok) sh <= {sh[DATA_W-2:0], 1'b0};
    end

    assign tx_bit = sh[DATA_W-1];

    assert_shift_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        (!sck_fall && !load) |=> $stable(sh));
endmodule

// File: rtl/spi_id_regslave.sv
module spi_id_regslave
    import spi_id_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   board_id,
    input  logic              spi_sel_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              reg_wr_en,
    output logic [LOC_W-1:0]  reg_wr_addr,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              reg_rd_en,
    output logic [LOC_W-1:0]  reg_rd_addr,
    input  logic [DATA_W-1:0] reg_rd_data
);
    logic    sel_act, sck_rise, sck_fall, mosi_bit;
    logic    tx_active, tx_shift_ok, tx_bit, rd_q;
    reg_wr_t wr;

    spi_sync_edge u_sync (
        .clk(clk), .rst(rst),
        .sel_n_in(spi_sel_n), .sck_in(spi_sck), .mosi_in(spi_mosi),
        .sel_act(sel_act), .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_bit(mosi_bit)
    );

    spi_frame_ctrl u_ctrl (
        .clk(clk), .rst(rst), .board_id(board_id),
        .sel_act(sel_act), .sck_rise(sck_rise), .mosi_bit(mosi_bit),
        .wr(wr), .rd_en(reg_rd_en), .loc_addr(reg_rd_addr),
        .tx_active(tx_active), .tx_shift_ok(tx_shift_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) rd_q <= 1'b0;
        else     rd_q <= reg_rd_en;
    end

    spi_tx_shifter u_tx (
        .clk(clk), .rst(rst), .load(rd_q), .load_data(reg_rd_data),
        .sck_fall(sck_fall), .shift_ok(tx_shift_ok), .tx_bit(tx_bit)
    );

    assign spi_miso_oe = tx_active;
    assign spi_miso    = tx_active & tx_bit;
    assign reg_wr_en   = wr.en;
    assign reg_wr_addr = wr.addr;
    assign reg_wr_data = wr.data;

    assert_oe_low_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !sel_act |=> !spi_miso_oe);
    assert_no_wr_during_tx_R4: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> !spi_miso_oe);
endmodule

// File: tb/spi_id_regslave_test.sv
module spi_id_regslave_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  board_id = 4'h5;
    logic        sel_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic        miso, miso_oe;
    logic        wr_en, rd_en;
    logic [11:0] wr_addr, rd_addr;
    logic [7:0]  wr_data, rd_data;

    int tests = 0, fails = 0;
    int wr_cnt = 0, rd_cnt = 0;
    logic [11:0] last_wr_addr = '0, last_rd_addr = '0;
    logic [7:0]  last_wr_data = '0;
    logic [7:0]  mem [16];

    always #10 clk = ~clk;

    spi_id_regslave uut (
        .clk(clk), .rst(rst), .board_id(board_id),
        .spi_sel_n(sel_n), .spi_sck(sck), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe),
        .reg_wr_en(wr_en), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data),
        .reg_rd_en(rd_en), .reg_rd_addr(rd_addr), .reg_rd_data(rd_data)
    );

    initial for (int i = 0; i < 16; i++) mem[i] = 8'h00;

    always @(posedge clk) begin
        if (rd_en) begin
            rd_data      <= mem[rd_addr[3:0]];
            rd_cnt       <= rd_cnt + 1;
            last_rd_addr <= rd_addr;
        end
        if (wr_en) begin
            mem[wr_addr[3:0]] <= wr_data;
            wr_cnt       <= wr_cnt + 1;
            last_wr_addr <= wr_addr;
            last_wr_data <= wr_data;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (8) @(negedge clk);
    endtask

    task automatic frame(input logic [15:0] a, input logic rw, input logic [7:0] wd,
                         input int nbits, input bit coinc,
                         output logic [7:0] rd, output bit oe_seen);
        logic [24:0] bits;
        bits = {a, rw, wd};
        rd = '0;
        oe_seen = 1'b0;
        sel_n = 1'b0;
        half();
        for (int i = 0; i < nbits; i++) begin
            mosi = bits[24-i];
            half();
            if (i >= 17) rd = {rd[6:0], miso};
            if (miso_oe) oe_seen = 1'b1;
            sck = 1'b1;
            if (coinc && i == nbits - 1) sel_n = 1'b1;
            half();
            sck = 1'b0;
        end
        half();
        sel_n = 1'b1;
        half();
        half();
    endtask

    task automatic t_reset();
        check(miso_oe == 1'b0, "R1 oe after reset", miso_oe, 0);
        check(miso == 1'b0, "R1 miso after reset", miso, 0);
        check(wr_cnt == 0 && rd_cnt == 0, "R1 no strobes after reset", wr_cnt + rd_cnt, 0);
    endtask

    task automatic t_write_read(input logic [11:0] a, input logic [7:0] d);
        logic [7:0] r;
        bit oe;
        int w0, r0;
        w0 = wr_cnt;
        frame({4'h5, a}, 1'b0, d, 25, 1'b0, r, oe);
        check(wr_cnt == w0 + 1, "R4 one write strobe", wr_cnt - w0, 1);
        check(last_wr_addr == a, "R2 write address order", last_wr_addr, a);
        check(last_wr_data == d, "R4 write data", last_wr_data, d);
        check(!oe, "R4 oe low on write", oe, 0);
        r0 = rd_cnt;
        frame({4'h5, a}, 1'b1, 8'h00, 25, 1'b0, r, oe);
        check(rd_cnt == r0 + 1, "R5 one read request", rd_cnt - r0, 1);
        check(last_rd_addr == a, "R5 read address", last_rd_addr, a);
        check(r == d, "R5 read data on miso", r, d);
        check(oe, "R5 oe during data phase", oe, 1);
    endtask

    task automatic t_mismatch();
        logic [7:0] r;
        bit oe;
        int w0, r0;
        w0 = wr_cnt;
        r0 = rd_cnt;
        frame(16'h40A3, 1'b0, 8'hFF, 25, 1'b0, r, oe);
        check(wr_cnt == w0, "R3 foreign id write ignored", wr_cnt - w0, 0);
        frame(16'h40A3, 1'b1, 8'h00, 25, 1'b0, r, oe);
        check(rd_cnt == r0, "R3 foreign id read ignored", rd_cnt - r0, 0);
        check(!oe, "R3 oe low for foreign id", oe, 0);
        check(mem[3] == 8'hA5, "R3 target byte untouched", mem[3], 8'hA5);
    endtask

    task automatic t_abort();
        logic [7:0] r;
        bit oe;
        int w0;
        w0 = wr_cnt;
        frame(16'h50A3, 1'b0, 8'h11, 10, 1'b0, r, oe);
        check(wr_cnt == w0, "R6 abort in address", wr_cnt - w0, 0);
        frame(16'h50A3, 1'b0, 8'h22, 21, 1'b0, r, oe);
        check(wr_cnt == w0, "R6 abort in data", wr_cnt - w0, 0);
        frame(16'h50A3, 1'b1, 8'h00, 25, 1'b0, r, oe);
        check(r == 8'hA5, "R6 byte kept after aborts", r, 8'hA5);
        frame(16'h5007, 1'b0, 8'h69, 25, 1'b0, r, oe);
        check(wr_cnt == w0 + 1 && last_wr_addr == 12'h007, "R6 next frame decodes",
              last_wr_addr, 12'h007);
    endtask

    task automatic t_coincident();
        logic [7:0] r;
        bit oe;
        int w0;
        w0 = wr_cnt;
        frame(16'h50A3, 1'b0, 8'h77, 25, 1'b1, r, oe);
        check(wr_cnt == w0, "R7 deselect beats last edge", wr_cnt - w0, 0);
        frame(16'h50A3, 1'b1, 8'h00, 25, 1'b0, r, oe);
        check(r == 8'hA5, "R7 byte unchanged", r, 8'hA5);
    endtask

    task automatic t_other_id();
        logic [7:0] r;
        bit oe;
        board_id = 4'hA;
        half();
        frame(16'hA00C, 1'b1, 8'h00, 25, 1'b0, r, oe);
        check(oe && last_rd_addr == 12'h00C, "R3 new id selects card", last_rd_addr, 12'h00C);
        check(r == 8'h00, "R5 read of blank byte", r, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_write_read(12'h0A3, 8'hA5);
        t_write_read(12'hFF1, 8'h3C);
        t_mismatch();
        t_abort();
        t_coincident();
        t_other_id();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule